// File: doc/BRIEF.md
# Phase Detector and Charge-Pump Control

This block sits between the reference divider, the feedback (LO) divider and the analog charge pump of a frequency synthesizer. It watches the rising edges of the two divided streams and keeps an "up" flag when the reference edge comes first and a "down" flag when the LO edge comes first. When the second edge arrives, both flags are held together for a short clear window and then drop. So a locked loop still produces narrow pulses in both directions. The flags become source and sink commands for the pump. A polarity bit can swap these commands. The pump mode can also force a steady source, a steady sink or a floating output for test, and a disabled synthesizer floats the pump.

A lock detector grades each comparison. A comparison counts as tight when the two edges are no more than one clock apart. Lock is declared after a programmable run of tight comparisons and is dropped at the first wider gap. The lock-detect pin is a four-way multiplexer that carries the lock status, a forced low, a read-back bit from the serial register file, or one of the two divided waveforms. The 2-bit current code is passed on to the analog current sources.

The detector is a four-state machine:
- `PS_IDLE`: no flag is set.
- `PS_LEAD_REF`: the up flag is set.
- `PS_LEAD_LO`: the down flag is set.
- `PS_CLEAR`: both flags are set.

Its transitions are:
- IDLE→LEAD_REF on a reference edge alone.
- IDLE→LEAD_LO on an LO edge alone.
- IDLE→CLEAR on both edges in the same cycle.
- LEAD_REF→CLEAR on an LO edge.
- LEAD_LO→CLEAR on a reference edge.
- CLEAR→IDLE after `RST_DLY` cycles.
- A repeated leading edge keeps the state where it is.

Top module: `cp_pfd_ctrl`

## Requirements
- R1: `pump_cur` always equals `cur_sel`. Codes 00, 01, 10 and 11 stand for 0.25, 0.50, 0.75 and 1.00 mA.
- R2: In normal mode with `pll_en`=1, a leading reference edge sets the up flag and a leading LO edge sets the down flag, from the clock edge that samples the leading edge onwards.
  - With `pump_pol`=0, up drives `pump_src` and down drives `pump_snk`.
  - With `pump_pol`=1, the two are swapped.
- R3: The clock edge that samples the second edge, or both edges together, sets both flags. Both flags stay set for exactly `RST_DLY` cycles, then the detector returns to idle. In normal mode an idle detector gives `pump_hiz`=1 and no source or sink.
- R4: A further rising edge on the leading input while it already leads leaves the same flag set, with no wrap to the other side.
- R5: `pump_mode` 01 forces source only, 10 forces sink only and 11 floats the pump (`pump_hiz`=1), whatever the detector state. Mode 00 is normal.
- R6: With `pll_en`=0 the pump floats, and the lock status is cleared and held at 0.
- R7: The lock status goes high at the clock edge that completes the `LOCK_CNT`-th consecutive comparison whose edge gap is 0 or 1 cycle.
- R8: A comparison whose leading flag stays set for a second cycle clears the lock status and the run of tight comparisons.
- R9: `ld_out` is selected by `ld_sel`:
  - 00 gives the lock status.
  - 01 gives 0.
  - 10 gives `rb_bit`.
  - 11 gives `lo_div` when `wave_sel`=1 and `ref_div` when `wave_sel`=0.
- R10: After reset the detector is idle, the lock status is 0, and the pump floats in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_div | input | 1 | Divided reference stream, synchronous level |
| lo_div | input | 1 | Divided LO stream, synchronous level |
| pll_en | input | 1 | Synthesizer enable |
| cur_sel | input | CUR_W | Pump current code |
| pump_pol | input | 1 | Swaps the source and sink commands in normal mode |
| pump_mode | input | 2 | 00 normal, 01 source, 10 sink, 11 float |
| ld_sel | input | 2 | Lock-detect pin source select |
| wave_sel | input | 1 | Waveform select for ld_sel=11 |
| rb_bit | input | 1 | Serial read-back bit |
| pump_src | output | 1 | Source current command |
| pump_snk | output | 1 | Sink current command |
| pump_hiz | output | 1 | Pump output floating |
| pump_cur | output | CUR_W | Current code to the analog stage |
| ld_out | output | 1 | Lock-detect pin |

## Verification
The assertions assume the following about the inputs:
- The divided streams are already synchronous to `clk`.
- Each rising edge is preceded by at least one low cycle.
- No new edge arrives while the detector is in its clear window, because edges in that window are not seen.

The stimulus keeps to this. Every comparison raises its edges from a low level, waits out the clear window and one idle cycle, and then returns both streams low before the next comparison. Mode bits change only between comparisons, so each comparison is graded under one steady setting.

// File: rtl/pfd_cp_pkg.sv
package pfd_cp_pkg;
    typedef enum logic [1:0] {
        PS_IDLE     = 2'd0,
        PS_LEAD_REF = 2'd1,
        PS_LEAD_LO  = 2'd2,
        PS_CLEAR    = 2'd3
    } pfd_state_t;

    localparam logic [1:0] PM_NORMAL    = 2'b00;
    localparam logic [1:0] PM_FORCE_SRC = 2'b01;
    localparam logic [1:0] PM_FORCE_SNK = 2'b10;
    localparam logic [1:0] PM_FLOAT     = 2'b11;

    localparam logic [1:0] LD_LOCK     = 2'b00;
    localparam logic [1:0] LD_GND      = 2'b01;
    localparam logic [1:0] LD_READBACK = 2'b10;
    localparam logic [1:0] LD_WAVE     = 2'b11;
endpackage

// File: rtl/pfd_cp_core.sv
module pfd_cp_core
    import pfd_cp_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_div,
    input  logic lo_div,
    output logic up_flag,
    output logic dn_flag,
    output logic lead_act,
    output logic cmp_done
);
    localparam int CW = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;
    localparam logic [CW-1:0] CLR_LAST = CW'(RST_DLY - 1);

    pfd_state_t state, nxt;
    logic       ref_q, lo_q;
    logic [CW-1:0] clr_cnt;
    logic       ref_rise, lo_rise;

    assign ref_rise = ref_div & ~ref_q;
    assign lo_rise  = lo_div & ~lo_q;

    // state register and clear-window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_IDLE;
            ref_q   <= 1'b0;
            lo_q    <= 1'b0;
            clr_cnt <= '0;
        end else begin
            state   <= nxt;
            ref_q   <= ref_div;
            lo_q    <= lo_div;
            clr_cnt <= (state == PS_CLEAR) ? clr_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE: begin
                if (ref_rise && lo_rise) nxt = PS_CLEAR;
                else if (ref_rise)       nxt = PS_LEAD_REF;
                else if (lo_rise)        nxt = PS_LEAD_LO;
            end
            PS_LEAD_REF: if (lo_rise)  nxt = PS_CLEAR;
            PS_LEAD_LO:  if (ref_rise) nxt = PS_CLEAR;
            PS_CLEAR:    if (clr_cnt == CLR_LAST) nxt = PS_IDLE;
            default:     nxt = PS_IDLE;
        endcase
    end

    // flag outputs
    always_comb begin
        up_flag  = (state == PS_LEAD_REF) || (state == PS_CLEAR);
        dn_flag  = (state == PS_LEAD_LO) || (state == PS_CLEAR);
        lead_act = (state == PS_LEAD_REF) || (state == PS_LEAD_LO);
        cmp_done = (state != PS_CLEAR) && (nxt == PS_CLEAR);
    end
endmodule

// File: rtl/pfd_cp_lock.sv
module pfd_cp_lock #(
    parameter int LOCK_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic lead_act,
    input  logic cmp_done,
    output logic locked
);
    localparam int LW = $clog2(LOCK_CNT + 1);
    localparam logic [LW-1:0] RUN_MAX = LW'(LOCK_CNT);

    logic [LW-1:0] run_cnt;
    logic          late;
    logic          tight, wide;

    // late: the leading flag was already set in the previous cycle
    assign tight = cmp_done && !late;
    assign wide  = lead_act && late;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            late    <= 1'b0;
            locked  <= 1'b0;
        end else begin
            late <= lead_act;
            if (!pll_en || wide) begin
                run_cnt <= '0;
                locked  <= 1'b0;
            end else if (tight) begin
                if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
                if (run_cnt >= RUN_MAX - 1'b1) locked <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfd_cp_drive.sv
module pfd_cp_drive
    import pfd_cp_pkg::*;
#(
    parameter int CUR_W = 2
) (
    input  logic             up_flag,
    input  logic             dn_flag,
    input  logic             locked,
    input  logic             pll_en,
    input  logic [CUR_W-1:0] cur_sel,
    input  logic             pump_pol,
    input  logic [1:0]       pump_mode,
    input  logic [1:0]       ld_sel,
    input  logic             wave_sel,
    input  logic             rb_bit,
    input  logic             ref_div,
    input  logic             lo_div,
    output logic             pump_src,
    output logic             pump_snk,
    output logic             pump_hiz,
    output logic [CUR_W-1:0] pump_cur,
    output logic             ld_out
);
    always_comb begin
        pump_src = 1'b0;
        pump_snk = 1'b0;
        if (pll_en) begin
            unique case (pump_mode)
                PM_NORMAL: begin
                    pump_src = pump_pol ? dn_flag : up_flag;
                    pump_snk = pump_pol ? up_flag : dn_flag;
                end
                PM_FORCE_SRC: pump_src = 1'b1;
                PM_FORCE_SNK: pump_snk = 1'b1;
                default: ;
            endcase
        end
        pump_hiz = !(pump_src || pump_snk);
        pump_cur = cur_sel;
    end

    always_comb begin
        unique case (ld_sel)
            LD_LOCK:     ld_out = locked;
            LD_GND:      ld_out = 1'b0;
            LD_READBACK: ld_out = rb_bit;
            default:     ld_out = wave_sel ? lo_div : ref_div;
        endcase
    end
endmodule

// File: rtl/cp_pfd_ctrl.sv
module cp_pfd_ctrl #(
    parameter int RST_DLY  = 2,
    parameter int LOCK_CNT = 4,
    parameter int CUR_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_div,
    input  logic             lo_div,
    input  logic             pll_en,
    input  logic [CUR_W-1:0] cur_sel,
    input  logic             pump_pol,
    input  logic [1:0]       pump_mode,
    input  logic [1:0]       ld_sel,
    input  logic             wave_sel,
    input  logic             rb_bit,
    output logic             pump_src,
    output logic             pump_snk,
    output logic             pump_hiz,
    output logic [CUR_W-1:0] pump_cur,
    output logic             ld_out
);
    logic up_w, dn_w, lead_w, done_w, locked_w;

    pfd_cp_core #(.RST_DLY(RST_DLY)) core_i (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .lo_div(lo_div),
        .up_flag(up_w), .dn_flag(dn_w), .lead_act(lead_w), .cmp_done(done_w)
    );

    pfd_cp_lock #(.LOCK_CNT(LOCK_CNT)) lock_i (
        .clk(clk), .rst_n(rst_n), .pll_en(pll_en),
        .lead_act(lead_w), .cmp_done(done_w), .locked(locked_w)
    );

    pfd_cp_drive #(.CUR_W(CUR_W)) drive_i (
        .up_flag(up_w), .dn_flag(dn_w), .locked(locked_w), .pll_en(pll_en),
        .cur_sel(cur_sel), .pump_pol(pump_pol), .pump_mode(pump_mode),
        .ld_sel(ld_sel), .wave_sel(wave_sel), .rb_bit(rb_bit),
        .ref_div(ref_div), .lo_div(lo_div),
        .pump_src(pump_src), .pump_snk(pump_snk), .pump_hiz(pump_hiz),
        .pump_cur(pump_cur), .ld_out(ld_out)
    );
endmodule

// File: rtl/cp_pfd_ctrl_chk.sv
module cp_pfd_ctrl_chk #(
    parameter int RST_DLY = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_en,
    input logic [1:0] pump_mode,
    input logic [1:0] ld_sel,
    input logic       up_flag,
    input logic       dn_flag,
    input logic       locked,
    input logic       pump_src,
    input logic       pump_snk,
    input logic       pump_hiz,
    input logic       ld_out
);
    assert_both_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(up_flag && dn_flag) && (RST_DLY > 1)) |=> (up_flag && dn_flag));

    assert_force_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && pump_mode == 2'b01) |-> (pump_src && !pump_snk && !pump_hiz));

    assert_off_floats_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> (pump_hiz && !pump_src && !pump_snk));

    assert_lock_on_tight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (up_flag && dn_flag));

    assert_wide_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_flag != dn_flag && $past(up_flag != dn_flag) && $past(up_flag) == up_flag)
        |=> !locked);

    assert_ld_gnd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel == 2'b01) |-> !ld_out);
endmodule

bind cp_pfd_ctrl cp_pfd_ctrl_chk #(.RST_DLY(RST_DLY)) chk_i (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .pump_mode(pump_mode),
    .ld_sel(ld_sel), .up_flag(up_w), .dn_flag(dn_w), .locked(locked_w),
    .pump_src(pump_src), .pump_snk(pump_snk), .pump_hiz(pump_hiz), .ld_out(ld_out)
);

// File: tb/cp_pfd_ctrl_tb_top.sv
module cp_pfd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RST_DLY    = 2;
    localparam int LOCK_CNT   = 4;
    localparam int CUR_W      = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0, lo_div = 1'b0;
    logic pll_en = 1'b1;
    logic [CUR_W-1:0] cur_sel = '0;
    logic pump_pol = 1'b0;
    logic [1:0] pump_mode = 2'b00, ld_sel = 2'b00;
    logic wave_sel = 1'b0, rb_bit = 1'b0;
    logic pump_src, pump_snk, pump_hiz, ld_out;
    logic [CUR_W-1:0] pump_cur;

    int n_chk = 0, n_fail = 0;
    int exp_run = 0;
    bit exp_lock = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cp_pfd_ctrl #(.RST_DLY(RST_DLY), .LOCK_CNT(LOCK_CNT), .CUR_W(CUR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .lo_div(lo_div),
        .pll_en(pll_en), .cur_sel(cur_sel), .pump_pol(pump_pol),
        .pump_mode(pump_mode), .ld_sel(ld_sel), .wave_sel(wave_sel),
        .rb_bit(rb_bit), .pump_src(pump_src), .pump_snk(pump_snk),
        .pump_hiz(pump_hiz), .pump_cur(pump_cur), .ld_out(ld_out)
    );

    // expected {src, snk, hiz}
    function automatic logic [2:0] exp_pump(bit up, bit dn);
        logic s, k;
        s = 1'b0; k = 1'b0;
        if (pll_en) begin
            case (pump_mode)
                2'b00: begin s = pump_pol ? dn : up; k = pump_pol ? up : dn; end
                2'b01: s = 1'b1;
                2'b10: k = 1'b1;
                default: ;
            endcase
        end
        return {s, k, !(s || k)};
    endfunction

    function automatic logic exp_ld();
        case (ld_sel)
            2'b00: return exp_lock;
            2'b01: return 1'b0;
            2'b10: return rb_bit;
            default: return wave_sel ? lo_div : ref_div;
        endcase
    endfunction

    task automatic chk(string rq, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic check_outs(string rq, string lk, bit up, bit dn, bit lock_ok);
        string prq;
        prq = !pll_en ? "R6" : (pump_mode != 2'b00) ? "R5" : rq;
        chk(prq, {1'b0, pump_src, pump_snk, pump_hiz}, {1'b0, exp_pump(up, dn)});
        chk("R1", {2'b0, pump_cur}, {2'b0, cur_sel});
        if (ld_sel != 2'b00) chk("R9", {3'b0, ld_out}, {3'b0, exp_ld()});
        else if (lock_ok)    chk(lk, {3'b0, ld_out}, {3'b0, exp_ld()});
    endtask

    // one comparison: leader rises, follower rises d cycles later
    task automatic compare(bit ref_first, int d, bit dbl);
        string lk;
        @(negedge clk);
        if (d == 0) begin ref_div = 1'b1; lo_div = 1'b1; end
        else if (ref_first) ref_div = 1'b1;
        else lo_div = 1'b1;
        for (int k = 0; k < d; k++) begin
            @(posedge clk); #1;
            check_outs(dbl ? "R4" : "R2", "R7", ref_first, !ref_first, 1'b0);
            @(negedge clk);
            if (dbl && k == 0) begin if (ref_first) ref_div = 1'b0; else lo_div = 1'b0; end
            if (dbl && k == 1) begin if (ref_first) ref_div = 1'b1; else lo_div = 1'b1; end
            if (k == d - 1) begin if (ref_first) lo_div = 1'b1; else ref_div = 1'b1; end
        end
        if (!pll_en) begin exp_run = 0; exp_lock = 1'b0; lk = "R6"; end
        else if (d <= 1) begin
            if (exp_run < LOCK_CNT) exp_run++;
            exp_lock = (exp_run >= LOCK_CNT);
            lk = "R7";
        end else begin exp_run = 0; exp_lock = 1'b0; lk = "R8"; end
        for (int k = 0; k < RST_DLY; k++) begin
            @(posedge clk); #1;
            check_outs("R3", lk, 1'b1, 1'b1, 1'b1);
        end
        @(posedge clk); #1;
        check_outs("R3", lk, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        ref_div = 1'b0; lo_div = 1'b0;
    endtask

    task automatic set_modes(bit en, logic [1:0] pm, bit pol, logic [1:0] ls);
        @(negedge clk);
        pll_en = en; pump_mode = pm; pump_pol = pol; ld_sel = ls;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_ed01));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R10 reset state
        chk("R10", {1'b0, pump_src, pump_snk, pump_hiz}, 4'b0001);
        chk("R10", {3'b0, ld_out}, 4'b0);

        // R7: run of tight comparisons reaches lock
        for (int i = 0; i < LOCK_CNT; i++) compare(i[0], i % 2, 1'b0);
        // R8: wide gap drops lock
        compare(1'b1, 3, 1'b0);
        for (int i = 0; i < LOCK_CNT; i++) compare(1'b0, 0, 1'b0);
        // R4: repeated leading edge
        compare(1'b1, 3, 1'b1);
        compare(1'b0, 4, 1'b1);
        // R2: swapped polarity
        set_modes(1'b1, 2'b00, 1'b1, 2'b00);
        compare(1'b0, 2, 1'b0);
        compare(1'b1, 1, 1'b0);
        // R5 forced modes, R9 selects
        set_modes(1'b1, 2'b01, 1'b0, 2'b11); wave_sel = 1'b1;
        compare(1'b1, 2, 1'b0);
        set_modes(1'b1, 2'b10, 1'b0, 2'b10); rb_bit = 1'b1;
        compare(1'b0, 2, 1'b0);
        set_modes(1'b1, 2'b11, 1'b0, 2'b01);
        compare(1'b1, 1, 1'b0);
        // R6 disabled
        set_modes(1'b0, 2'b00, 1'b0, 2'b00);
        compare(1'b1, 0, 1'b0);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int d;
            @(negedge clk);
            pll_en    = ($urandom % 10) != 0;
            pump_mode = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            pump_pol  = 1'($urandom);
            ld_sel    = 2'($urandom);
            wave_sel  = 1'($urandom);
            rb_bit    = 1'($urandom);
            cur_sel   = CUR_W'($urandom);
            d = ($urandom % 5 < 3) ? int'($urandom % 2) : int'($urandom % 5);
            compare(1'($urandom), d, (d >= 3) && 1'($urandom));
            repeat ($urandom % 3) @(negedge clk);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule